// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block sits on the host side of an asynchronous parallel NOR flash bus. It turns one request into the full unlock sequence of strobed command writes that the memory needs before it accepts a change. A request is either a single-word program, a sector erase or a whole-array erase. The sequencer then polls the memory until the internal operation ends. Requests arrive over a valid/ready handshake. The sequencer answers each one with a single-cycle done pulse, which carries a timeout flag and a readback-mismatch flag.

All strobe widths and gaps are counted in system clock cycles and set by parameters. Chip enable stays low from the first write to the last read. Output enable never falls while the sequencer drives the data bus, because a read in the middle of a command sequence makes the memory abandon it. Completion is found by reading the poll address again and again until two reads in a row return the same value on data bit 6. After a word program the sequencer can read the word back once and compare it with the data written.

Top module: `flash_cmd_seq`

## Requirements
- R1: A request is taken on a rising clock edge where `req_valid_i` and `req_ready_o` are both high. `req_ready_o` is high only while the sequencer is idle, and stays low from acceptance until the cycle of the done pulse. In that cycle a new request can already be accepted.
- R2: The operation code is 2'b00 program, 2'b01 sector erase, 2'b10 chip erase, 2'b11 reserved. A program issues exactly four writes: 0xAA at 0x5555, 0x55 at 0x2AAA, 0xA0 at 0x5555, then the request data at the request address. Command bytes sit in bits 7:0 with all upper data bits zero. Command addresses are zero-extended.
- R3: A sector erase issues exactly six writes: 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, then 0x30 at the request address.
- R4: A chip erase issues the same first five writes as a sector erase, and its sixth write is 0x10@0x5555.
- R5: Each write-enable low pulse lasts at least `WE_LOW_CYC` cycles. Between two pulses, write-enable stays high for at least `WE_HIGH_CYC` cycles. Address and data are held constant from the falling strobe until the end of the high phase that follows it.
- R6: Output enable is high whenever the data bus is driven. Chip enable is low for the whole operation and high while idle.
- R7: The first poll read starts no sooner than `WE_HIGH_CYC` cycles after the last write strobe rises. Every read holds output enable low for `RD_CYC` cycles at the request address.
- R8: When two back-to-back reads return the same bit 6, the operation ends with `done_o` high for one cycle and `timeout_o` low.
- R9: If `POLL_LIMIT` reads pass without a matching pair, the operation ends with `done_o` and `timeout_o` both high, and no further read is made.
- R10: With `req_verify_i` set on a program request, one extra read follows completion. `verify_err_o` is raised with `done_o` when that read differs from the programmed data. Without the flag, or for any erase, no extra read is made and `verify_err_o` stays low.
- R11: A reserved operation code causes no bus activity and gives `done_o` on the cycle after acceptance.
- R12: During and right after reset, the bus is idle (all strobes high, data bus not driven), `req_ready_o` is high and `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Sequencer idle and able to accept |
| req_op_i | input | 2 | Operation code |
| req_addr_i | input | AW | Target word address or sector address |
| req_data_i | input | DW | Word to program |
| req_verify_i | input | 1 | Read back after a program |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| timeout_o | output | 1 | Poll limit reached; valid with done_o |
| verify_err_o | output | 1 | Readback mismatch; valid with done_o |
| flash_ce_n_o | output | 1 | Chip enable, active low |
| flash_oe_n_o | output | 1 | Output enable, active low |
| flash_we_n_o | output | 1 | Write enable, active low |
| flash_addr_o | output | AW | Flash address |
| flash_dq_o | output | DW | Data driven to flash |
| flash_dq_oe_o | output | 1 | Data bus drive enable |
| flash_dq_i | input | DW | Data read from flash |

## Verification
Two things can fall in the same cycle: the end of one operation and the acceptance of the next. The done pulse is raised in the first idle cycle, and ready is already high in that cycle. To provoke the overlap, the bench holds a second request valid for the whole of a running program. It then checks that done and ready are both high at one sampling point. It also checks that the first operation's write list is unchanged by the waiting request, and that the second operation then issues its own full write list. The polling model in the bench sets the bit-6 pattern for each case, which decides exactly how many reads must be seen before done.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  typedef enum logic [1:0] {
    OP_PROG = 2'b00,
    OP_SECT = 2'b01,
    OP_CHIP = 2'b10,
    OP_NONE = 2'b11
  } fseq_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WR_LO,
    S_WR_HI,
    S_RD_LO,
    S_RD_GAP
  } fseq_state_e;

  localparam logic [14:0] ADDR_A = 15'h5555;
  localparam logic [14:0] ADDR_B = 15'h2AAA;
  localparam logic [7:0]  CMD_K1 = 8'hAA;
  localparam logic [7:0]  CMD_K2 = 8'h55;
  localparam logic [7:0]  CMD_PGM = 8'hA0;
  localparam logic [7:0]  CMD_ERS = 8'h80;
  localparam logic [7:0]  CMD_SEC = 8'h30;
  localparam logic [7:0]  CMD_ALL = 8'h10;
endpackage

// File: rtl/fseq_step_gen.sv
module fseq_step_gen
  import fseq_pkg::*;
#(
  parameter int AW = 17,
  parameter int DW = 16
) (
  input  fseq_op_e        op_i,
  input  logic [2:0]      idx_i,
  input  logic [AW-1:0]   tgt_addr_i,
  input  logic [DW-1:0]   tgt_data_i,
  output logic [AW-1:0]   addr_o,
  output logic [DW-1:0]   data_o,
  output logic            last_o
);
  localparam int AP = AW - 15;
  localparam int DP = DW - 8;

  logic [AW-1:0] a_a, a_b;
  assign a_a = {{AP{1'b0}}, ADDR_A};
  assign a_b = {{AP{1'b0}}, ADDR_B};

  function automatic logic [DW-1:0] cmd(input logic [7:0] b);
    return {{DP{1'b0}}, b};
  endfunction

  assign last_o = (op_i == OP_PROG) ? (idx_i == 3'd3) : (idx_i == 3'd5);

  always_comb begin
    addr_o = a_a;
    data_o = cmd(CMD_K1);
    unique case (idx_i)
      3'd0: begin addr_o = a_a; data_o = cmd(CMD_K1); end
      3'd1: begin addr_o = a_b; data_o = cmd(CMD_K2); end
      3'd2: begin
        addr_o = a_a;
        data_o = (op_i == OP_PROG) ? cmd(CMD_PGM) : cmd(CMD_ERS);
      end
      3'd3: begin
        if (op_i == OP_PROG) begin
          addr_o = tgt_addr_i;
          data_o = tgt_data_i;
        end else begin
          addr_o = a_a;
          data_o = cmd(CMD_K1);
        end
      end
      3'd4: begin addr_o = a_b; data_o = cmd(CMD_K2); end
      default: begin
        if (op_i == OP_SECT) begin
          addr_o = tgt_addr_i;
          data_o = cmd(CMD_SEC);
        end else begin
          addr_o = a_a;
          data_o = cmd(CMD_ALL);
        end
      end
    endcase
  end
endmodule

// File: rtl/fseq_toggle_det.sv
module fseq_toggle_det #(
  parameter int POLL_LIMIT = 2_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic sample_i,
  input  logic bit_i,
  output logic settled_o,
  output logic exhausted_o
);
  localparam int PW = $clog2(POLL_LIMIT + 1);

  logic [PW-1:0] polls_q;
  logic          prev_q;
  logic          have_q;

  assign settled_o   = sample_i && have_q && (bit_i == prev_q);
  assign exhausted_o = sample_i && !settled_o && (polls_q == PW'(POLL_LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      polls_q <= '0;
      prev_q  <= 1'b0;
      have_q  <= 1'b0;
    end else if (clear_i) begin
      polls_q <= '0;
      have_q  <= 1'b0;
    end else if (sample_i) begin
      polls_q <= polls_q + 1'b1;
      prev_q  <= bit_i;
      have_q  <= 1'b1;
    end
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fseq_pkg::*;
#(
  parameter int AW          = 17,
  parameter int DW          = 16,
  parameter int WE_LOW_CYC  = 4,
  parameter int WE_HIGH_CYC = 5,
  parameter int RD_CYC      = 4,
  parameter int RD_GAP_CYC  = 2,
  parameter int POLL_LIMIT  = 2_000_000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [1:0]    req_op_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_data_i,
  input  logic          req_verify_i,
  output logic          done_o,
  output logic          timeout_o,
  output logic          verify_err_o,
  output logic          flash_ce_n_o,
  output logic          flash_oe_n_o,
  output logic          flash_we_n_o,
  output logic [AW-1:0] flash_addr_o,
  output logic [DW-1:0] flash_dq_o,
  output logic          flash_dq_oe_o,
  input  logic [DW-1:0] flash_dq_i
);
  localparam int M1   = (WE_LOW_CYC > WE_HIGH_CYC) ? WE_LOW_CYC : WE_HIGH_CYC;
  localparam int M2   = (RD_CYC > RD_GAP_CYC) ? RD_CYC : RD_GAP_CYC;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXC + 1);

  fseq_state_e   state_q;
  fseq_op_e      op_q;
  logic [CW-1:0] cnt_q;
  logic [2:0]    step_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          vfy_q, chk_q;
  logic          done_q, to_q, err_q;

  logic [AW-1:0] st_addr;
  logic [DW-1:0] st_data;
  logic          st_last;
  logic          rd_sample, settled, exhausted;

  fseq_step_gen #(.AW(AW), .DW(DW)) i_step (
    .op_i       (op_q),
    .idx_i      (step_q),
    .tgt_addr_i (addr_q),
    .tgt_data_i (data_q),
    .addr_o     (st_addr),
    .data_o     (st_data),
    .last_o     (st_last)
  );

  assign rd_sample = (state_q == S_RD_LO) && (cnt_q == '0);

  fseq_toggle_det #(.POLL_LIMIT(POLL_LIMIT)) i_tog (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (state_q == S_IDLE),
    .sample_i    (rd_sample && !chk_q),
    .bit_i       (flash_dq_i[6]),
    .settled_o   (settled),
    .exhausted_o (exhausted)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      op_q    <= OP_NONE;
      cnt_q   <= '0;
      step_q  <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      vfy_q   <= 1'b0;
      chk_q   <= 1'b0;
      done_q  <= 1'b0;
      to_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      to_q   <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        S_IDLE: if (req_valid_i) begin
          op_q   <= fseq_op_e'(req_op_i);
          addr_q <= req_addr_i;
          data_q <= req_data_i;
          vfy_q  <= req_verify_i;
          chk_q  <= 1'b0;
          step_q <= '0;
          if (fseq_op_e'(req_op_i) == OP_NONE) begin
            done_q <= 1'b1;
          end else begin
            state_q <= S_WR_LO;
            cnt_q   <= CW'(WE_LOW_CYC - 1);
          end
        end
        S_WR_LO: if (cnt_q == '0) begin
          state_q <= S_WR_HI;
          cnt_q   <= CW'(WE_HIGH_CYC - 1);
        end else cnt_q <= cnt_q - 1'b1;
        S_WR_HI: if (cnt_q == '0) begin
          if (st_last) begin
            state_q <= S_RD_LO;
            cnt_q   <= CW'(RD_CYC - 1);
          end else begin
            step_q  <= step_q + 1'b1;
            state_q <= S_WR_LO;
            cnt_q   <= CW'(WE_LOW_CYC - 1);
          end
        end else cnt_q <= cnt_q - 1'b1;
        S_RD_LO: if (cnt_q == '0) begin
          if (chk_q) begin
            err_q   <= (flash_dq_i != data_q);
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end else if (settled) begin
            if (op_q == OP_PROG && vfy_q) begin
              chk_q   <= 1'b1;
              state_q <= S_RD_GAP;
              cnt_q   <= CW'(RD_GAP_CYC - 1);
            end else begin
              done_q  <= 1'b1;
              state_q <= S_IDLE;
            end
          end else if (exhausted) begin
            to_q    <= 1'b1;
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            state_q <= S_RD_GAP;
            cnt_q   <= CW'(RD_GAP_CYC - 1);
          end
        end else cnt_q <= cnt_q - 1'b1;
        S_RD_GAP: if (cnt_q == '0) begin
          state_q <= S_RD_LO;
          cnt_q   <= CW'(RD_CYC - 1);
        end else cnt_q <= cnt_q - 1'b1;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  logic wr_phase;
  assign wr_phase      = (state_q == S_WR_LO) || (state_q == S_WR_HI);
  assign req_ready_o   = (state_q == S_IDLE);
  assign done_o        = done_q;
  assign timeout_o     = to_q;
  assign verify_err_o  = err_q;
  assign flash_ce_n_o  = (state_q == S_IDLE);
  assign flash_we_n_o  = (state_q != S_WR_LO);
  assign flash_oe_n_o  = (state_q != S_RD_LO);
  assign flash_dq_oe_o = wr_phase;
  assign flash_addr_o  = wr_phase ? st_addr : addr_q;
  assign flash_dq_o    = wr_phase ? st_data : '0;
endmodule

// File: rtl/fseq_checker.sv
module fseq_checker #(
  parameter int AW          = 17,
  parameter int DW          = 16,
  parameter int WE_LOW_CYC  = 4,
  parameter int WE_HIGH_CYC = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ce_n,
  input logic          oe_n,
  input logic          we_n,
  input logic          dq_oe,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] dq,
  input logic          ready,
  input logic          done,
  input logic          timeout,
  input logic          verr
);
  localparam int SAT = (WE_LOW_CYC > WE_HIGH_CYC) ? WE_LOW_CYC : WE_HIGH_CYC;
  localparam int CW  = $clog2(SAT + 1);

  logic [CW-1:0] lo_run, hi_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_run <= '0;
      hi_run <= CW'(SAT);
    end else begin
      lo_run <= !we_n ? ((lo_run == CW'(SAT)) ? lo_run : lo_run + 1'b1) : '0;
      hi_run <= we_n ? ((hi_run == CW'(SAT)) ? hi_run : hi_run + 1'b1) : '0;
    end
  end

  AST_WE_LOW_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_n) |-> lo_run >= CW'(WE_LOW_CYC)); // R5
  AST_WE_HIGH_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(we_n) |-> hi_run >= CW'(WE_HIGH_CYC)); // R5
  AST_WR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dq_oe && $past(dq_oe) && $past(!we_n)) |-> ($stable(addr) && $stable(dq))); // R5
  AST_NO_READ_IN_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe |-> oe_n); // R6
  AST_CE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready |-> ce_n); // R6
  AST_POLL_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_n) |-> hi_run >= CW'(WE_HIGH_CYC)); // R7
  AST_TIMEOUT_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout |-> (done && !verr)); // R9
  AST_VERR_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    verr |-> done); // R10
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> !done || $past(ready)); // R8
endmodule

bind flash_cmd_seq fseq_checker #(
  .AW(AW), .DW(DW), .WE_LOW_CYC(WE_LOW_CYC), .WE_HIGH_CYC(WE_HIGH_CYC)
) i_fseq_checker (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ce_n    (flash_ce_n_o),
  .oe_n    (flash_oe_n_o),
  .we_n    (flash_we_n_o),
  .dq_oe   (flash_dq_oe_o),
  .addr    (flash_addr_o),
  .dq      (flash_dq_o),
  .ready   (req_ready_o),
  .done    (done_o),
  .timeout (timeout_o),
  .verr    (verify_err_o)
);

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;
  localparam int AW = 17;
  localparam int DW = 16;
  localparam int LIM = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic req_vfy = 1'b0;
  logic req_ready, done, tmo, verr;
  logic ce_n, oe_n, we_n, dq_oe;
  logic [AW-1:0] f_addr;
  logic [DW-1:0] f_dq_o;
  logic [DW-1:0] cur = '0;

  always #10 clk = ~clk;

  flash_cmd_seq #(.AW(AW), .DW(DW), .POLL_LIMIT(LIM)) i_flash_cmd_seq (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_addr_i(req_addr), .req_data_i(req_data),
    .req_verify_i(req_vfy),
    .done_o(done), .timeout_o(tmo), .verify_err_o(verr),
    .flash_ce_n_o(ce_n), .flash_oe_n_o(oe_n), .flash_we_n_o(we_n),
    .flash_addr_o(f_addr), .flash_dq_o(f_dq_o), .flash_dq_oe_o(dq_oe),
    .flash_dq_i(cur)
  );

  int n_chk = 0, n_fail = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // flash model and bus monitor
  int busy_left, nw, nr, lo_run, hi_run, min_lo, min_hi, gap_first;
  int oe_viol, ce_viol, addr_viol;
  logic tog;
  logic [DW-1:0] fin;
  logic [AW-1:0] cap_a [0:7];
  logic [DW-1:0] cap_d [0:7];
  logic prev_we = 1'b1, prev_oe = 1'b1;

  task automatic model_reset(input int busy, input logic [DW-1:0] f);
    busy_left = busy; fin = f; tog = 1'b0; cur = '0;
    nw = 0; nr = 0; lo_run = 0; hi_run = 100; min_lo = 999; min_hi = 999;
    gap_first = -1; oe_viol = 0; ce_viol = 0; addr_viol = 0;
  endtask

  always begin
    @(posedge clk); #5;
    if (!oe_n && prev_oe) begin
      if (nr == 0) gap_first = hi_run;
      nr++;
      if (busy_left > 0) begin
        tog = ~tog; cur = tog ? 16'h0040 : 16'h0000; busy_left--;
      end else cur = fin;
    end
    if (!oe_n && f_addr != req_addr) addr_viol++;
    if (we_n && !prev_we) begin
      if (nw < 8) begin cap_a[nw] = f_addr; cap_d[nw] = f_dq_o; end
      nw++;
      if (lo_run < min_lo) min_lo = lo_run;
      hi_run = 1;
    end else if (we_n) hi_run++;
    if (!we_n && prev_we) begin
      if (nw > 0 && hi_run < min_hi) min_hi = hi_run;
      lo_run = 1;
    end else if (!we_n) lo_run++;
    if (!oe_n && dq_oe) oe_viol++;
    if (!req_ready && ce_n) ce_viol++;
    prev_we = we_n; prev_oe = oe_n;
  end

  function automatic logic [AW+DW-1:0] exp_wr(input logic [1:0] op, input int i,
                                               input logic [AW-1:0] a, input logic [DW-1:0] d);
    case (i)
      0: return {17'h05555, 16'h00AA};
      1: return {17'h02AAA, 16'h0055};
      2: return {17'h05555, (op == 2'b00) ? 16'h00A0 : 16'h0080};
      3: return (op == 2'b00) ? {a, d} : {17'h05555, 16'h00AA};
      4: return {17'h02AAA, 16'h0055};
      default: return (op == 2'b01) ? {a, 16'h0030} : {17'h05555, 16'h0010};
    endcase
  endfunction

  function automatic int exp_reads(input int busy, input logic f6);
    if (busy == 0) return 2;
    return (f6 == logic'(busy % 2)) ? busy + 1 : busy + 2;
  endfunction

  task automatic issue(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic v, input int busy, input logic [DW-1:0] f);
    @(negedge clk);
    model_reset(busy, f);
    req_op = op; req_addr = a; req_data = d; req_vfy = v; req_valid = 1'b1;
    @(posedge clk); #1 req_valid = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 0;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if (done) begin seen = 1; break; end
      check(!req_ready, "R1 ready low while busy", req_ready, 0);
    end
  endtask

  task automatic check_op(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input int exp_r, input bit e_to, input bit e_err);
    int ew;
    string rq;
    ew = (op == 2'b00) ? 4 : 6;
    rq = (op == 2'b00) ? "R2" : (op == 2'b01) ? "R3" : "R4";
    check(nw == ew, {rq, " write count"}, nw, ew);
    for (int i = 0; i < ew && i < 8; i++)
      check({cap_a[i], cap_d[i]} == exp_wr(op, i, a, d), {rq, " write content"},
            {cap_a[i], cap_d[i]}, exp_wr(op, i, a, d));
    check(min_lo >= 4, "R5 we low width", min_lo, 4);
    check(min_hi >= 5, "R5 we high gap", min_hi, 5);
    check(oe_viol == 0 && ce_viol == 0, "R6 strobe overlap", oe_viol + ce_viol, 0);
    check(gap_first >= 5, "R7 poll gap", gap_first, 5);
    check(addr_viol == 0, "R7 poll address", addr_viol, 0);
    check(nr == exp_r, "R8 read count", nr, exp_r);
    check(tmo == e_to, "R9 timeout flag", tmo, e_to);
    check(verr == e_err, "R10 verify flag", verr, e_err);
  endtask

  typedef struct packed {
    logic [1:0]    op;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic          vfy;
    logic [3:0]    busy;
    logic [DW-1:0] fin;
    logic          err;
  } vec_t;

  localparam vec_t VECS [0:6] = '{
    '{2'b00, 17'h00123, 16'h1234, 1'b1, 4'd3, 16'h1234, 1'b0},
    '{2'b00, 17'h1F000, 16'hABCD, 1'b1, 4'd2, 16'hABC0, 1'b1},
    '{2'b00, 17'h00040, 16'h00FF, 1'b0, 4'd0, 16'h00FF, 1'b0},
    '{2'b01, 17'h03000, 16'h0000, 1'b0, 4'd5, 16'hFFFF, 1'b0},
    '{2'b10, 17'h1ABCD, 16'h0000, 1'b0, 4'd4, 16'hFFFF, 1'b0},
    '{2'b00, 17'h00777, 16'h5555, 1'b0, 4'd1, 16'h0000, 1'b0},
    '{2'b01, 17'h05000, 16'h0000, 1'b1, 4'd1, 16'hFFFF, 1'b0}
  };

  initial begin
    #3_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    bit seen;
    int er;
    model_reset(0, '0);
    // R12 reset state
    repeat (3) @(negedge clk);
    check(ce_n && oe_n && we_n && !dq_oe, "R12 bus idle in reset", {ce_n, oe_n, we_n, dq_oe}, 4'b1110);
    check(req_ready && !done, "R12 ready in reset", {req_ready, done}, 2'b10);
    rst_ni = 1'b1;
    @(negedge clk);
    check(ce_n && we_n && oe_n && req_ready && !done, "R12 idle after reset",
          {ce_n, we_n, oe_n, req_ready, done}, 5'b11110);

    foreach (VECS[i]) begin
      issue(VECS[i].op, VECS[i].addr, VECS[i].data, VECS[i].vfy, int'(VECS[i].busy), VECS[i].fin);
      wait_done(seen);
      check(seen, "R8 done seen", seen, 1);
      er = exp_reads(int'(VECS[i].busy), VECS[i].fin[6]);
      if (VECS[i].op == 2'b00 && VECS[i].vfy) er++;
      check_op(VECS[i].op, VECS[i].addr, VECS[i].data, er, 1'b0, VECS[i].err);
      @(negedge clk);
      check(!done, "R8 done one cycle", done, 0);
    end

    // R9 timeout, program with verify: no verify read after timeout
    issue(2'b00, 17'h00500, 16'h0F0F, 1'b1, 100, 16'h0F0F);
    wait_done(seen);
    check(seen, "R9 done on timeout", seen, 1);
    check_op(2'b00, 17'h00500, 16'h0F0F, LIM, 1'b1, 1'b0);

    // R11 reserved code
    issue(2'b11, 17'h00001, 16'h0001, 1'b0, 0, '0);
    @(negedge clk);
    check(done && !tmo && !verr, "R11 done next cycle", {done, tmo, verr}, 3'b100);
    check(nw == 0 && nr == 0 && ce_viol == 0 && ce_n, "R11 no bus activity", nw + nr, 0);

    // R1 back-to-back: second request held valid across first operation
    issue(2'b00, 17'h00222, 16'h3333, 1'b0, 1, 16'h3333);
    @(negedge clk);
    req_op = 2'b01; req_addr = 17'h03000; req_data = 16'h0000; req_vfy = 1'b0; req_valid = 1'b1;
    req_addr = 17'h00222; // poll address of the running op until handover
    seen = 0;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if (done) begin seen = 1; break; end
    end
    check(seen && req_ready, "R1 done and ready in same cycle", {seen, req_ready}, 2'b11);
    check_op(2'b00, 17'h00222, 16'h3333, exp_reads(1, 1'b0), 1'b0, 1'b0);
    model_reset(2, 16'hFFFF);
    req_addr = 17'h03000;
    @(posedge clk); #1 req_valid = 1'b0;
    wait_done(seen);
    check(seen, "R1 second op done", seen, 1);
    check_op(2'b01, 17'h03000, 16'h0000, exp_reads(2, 1'b1), 1'b0, 1'b0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule